// File: doc/BRIEF.md
# Mixed-Access Control Register Bank

This block is a bank of 32-bit control and status registers reached over a small request/acknowledge register bus. The bus carries up to 64 bits of data. Each request gives a byte address, a byte count of 4 or 8, a read/write flag and write data. The block decodes the address to a register index, which is the byte address divided by four. It checks that the access is legal, returns read data, and updates storage. Each register follows its own write rule: plain read/write, read-only, write-one-to-clear, or write-one-to-set.

An 8-byte access touches a pair of neighbouring registers. Such an access is only accepted inside a scratchpad window at the top of the map. An 8-byte write stores raw data into both registers of the pair and bypasses the per-register rules. Any rejected access leaves storage untouched. It is answered with an error flag that comes with the acknowledge pulse.

Top module: `ctl_reg_bank`

## Requirements
- R1: After a synchronous active-low reset, `req_ready`, `rsp_err` and `rsp_rdata` are zero. Register 0 (identity) reads `ID_VAL`. Register 1 (strap) reads `STRAP_VAL`. Register 3 (reset cause) reads `RST_VAL`. Register 4 (boot status) reads `BOOT_VAL`. Every other register reads zero.
- R2: A request is taken on a clock edge where `req_valid` is high and `req_ready` is low. On the following cycle, `req_ready` is high for exactly one cycle, together with that request's `rsp_rdata` and `rsp_err`. In every other cycle, `rsp_err` and `rsp_rdata` are zero.
- R3: A legal 4-byte read returns the addressed register in bits 31:0 and zero in bits 63:32.
- R4: A 4-byte write to a register with no special rule stores `req_wdata[31:0]`.
- R5: A 4-byte write to register 0, 1 or 2 (identity, strap, interrupt status, all read-only) changes nothing and returns `rsp_err`=1.
- R6: A 4-byte write to register 3 or 4 (write-one-to-clear) leaves old AND NOT `req_wdata[31:0]` in the register.
- R7: A 4-byte write to register 5 or 6 (lock, module disable; write-one-to-set) leaves old OR `req_wdata[31:0]` in the register.
- R8: A legal 8-byte read at index N returns register N in bits 31:0 and register N+1 in bits 63:32.
- R9: A legal 8-byte write at index N stores bits 31:0 into register N and bits 63:32 into register N+1, with no write rule applied.
- R10: An 8-byte access is legal only when its index is at least `SCRATCH_BASE` (56) and below `NUM_REGS-1`. Outside that window it returns `rsp_err`=1 and changes nothing.
- R11: An access whose index is `NUM_REGS` (64) or above returns `rsp_err`=1 and `rsp_rdata`=0, and changes nothing. Any errored response carries zero read data.
- R12: A `req_size` other than 4 or 8 is rejected with `rsp_err`=1 and no change. So is a 4-byte access with `req_addr[1:0]`≠0, and an 8-byte access with `req_addr[2:0]`≠0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Byte address |
| req_size | input | 4 | Access size in bytes (4 or 8 legal) |
| req_wdata | input | 64 | Write data; bits 31:0 only for 4-byte writes |
| req_ready | output | 1 | One-cycle acknowledge |
| rsp_rdata | output | 64 | Read data, valid with `req_ready` |
| rsp_err | output | 1 | Error flag, valid with `req_ready` |

## Verification
The bench goes after the edges of the scratchpad window and after accesses that are misaligned or of an odd size. A decoder that mis-placed the window would accept a pair straddling plain registers, or would refuse the top pair. The bench also writes to each register with a special rule. A design that applied the wrong rule would set bits in a clear-only register, lose bits in a set-only register, or overwrite the identity value. Separate checks confirm that 8-byte writes bypass the rules and place both halves in the right registers. Read-backs after every rejected access show that no error path leaked a write.

// File: rtl/cr_pkg.sv
// Package: shared types and helper functions for the register bank.
// Assumes special register indices are distinct and below the register count.
package cr_pkg;

    typedef enum logic [1:0] {
        RULE_RW  = 2'd0,
        RULE_RO  = 2'd1,
        RULE_W1C = 2'd2,
        RULE_W1S = 2'd3
    } wr_rule_e;

    // Classify a register index into its 4-byte write rule.
    function automatic wr_rule_e rule_of(
        input int i,
        input int id_i, input int strap_i, input int irq_i,
        input int rst_i, input int boot_i,
        input int lock_i, input int mdis_i
    );
        if (i == id_i || i == strap_i || i == irq_i) return RULE_RO;
        if (i == rst_i || i == boot_i)               return RULE_W1C;
        if (i == lock_i || i == mdis_i)              return RULE_W1S;
        return RULE_RW;
    endfunction

    // Merge 4-byte write data into the current value under a rule.
    function automatic logic [31:0] apply_rule(
        input wr_rule_e    r,
        input logic [31:0] cur,
        input logic [31:0] wd
    );
        case (r)
            RULE_RO:  return cur;
            RULE_W1C: return cur & ~wd;
            RULE_W1S: return cur | wd;
            default:  return wd;
        endcase
    endfunction

    // Reset value of a register index.
    function automatic logic [31:0] reset_of(
        input int i,
        input int id_i,    input logic [31:0] id_v,
        input int strap_i, input logic [31:0] strap_v,
        input int rst_i,   input logic [31:0] rst_v,
        input int boot_i,  input logic [31:0] boot_v
    );
        if (i == id_i)    return id_v;
        if (i == strap_i) return strap_v;
        if (i == rst_i)   return rst_v;
        if (i == boot_i)  return boot_v;
        return 32'h0;
    endfunction

endpackage

// File: rtl/cr_decode.sv
// Module: address decode and legality check for one request.
// Assumes ADDR_W >= 3 and NUM_REGS fits in the index field.
module cr_decode
    import cr_pkg::*;
#(
    parameter int NUM_REGS     = 64,
    parameter int ADDR_W       = 12,
    parameter int SCRATCH_BASE = 56,
    parameter int ID_IDX       = 0,
    parameter int STRAP_IDX    = 1,
    parameter int IRQ_IDX      = 2,
    parameter int RST_IDX      = 3,
    parameter int BOOT_IDX     = 4,
    parameter int LOCK_IDX     = 5,
    parameter int MDIS_IDX     = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        size,
    input  logic              write,
    output logic [ADDR_W-3:0] idx,
    output logic              wide,
    output logic              legal
);

    logic size_ok, align_ok, range_ok, window_ok, ro_hit;

    // Derive index and combine every legality condition.
    always_comb begin
        idx       = addr[ADDR_W-1:2];
        wide      = (size == 4'd8);
        size_ok   = (size == 4'd4) || wide;
        align_ok  = wide ? (addr[2:0] == 3'b000) : (addr[1:0] == 2'b00);
        range_ok  = int'(idx) < NUM_REGS;
        window_ok = !wide || ((int'(idx) >= SCRATCH_BASE) && (int'(idx) < NUM_REGS - 1));
        ro_hit    = write && !wide &&
                    (rule_of(int'(idx), ID_IDX, STRAP_IDX, IRQ_IDX, RST_IDX,
                             BOOT_IDX, LOCK_IDX, MDIS_IDX) == RULE_RO);
        legal     = size_ok && align_ok && range_ok && window_ok && !ro_hit;
    end

endmodule

// File: rtl/cr_store.sv
// Module: register storage with per-register write rules.
// Assumes wr_en is only raised for legal accesses.
module cr_store
    import cr_pkg::*;
#(
    parameter int          NUM_REGS  = 64,
    parameter int          IDX_W     = 10,
    parameter int          ID_IDX    = 0,
    parameter int          STRAP_IDX = 1,
    parameter int          IRQ_IDX   = 2,
    parameter int          RST_IDX   = 3,
    parameter int          BOOT_IDX  = 4,
    parameter int          LOCK_IDX  = 5,
    parameter int          MDIS_IDX  = 6,
    parameter logic [31:0] ID_VAL    = 32'h0A92_1B47,
    parameter logic [31:0] STRAP_VAL = 32'h0000_3C5F,
    parameter logic [31:0] RST_VAL   = 32'h0000_0001,
    parameter logic [31:0] BOOT_VAL  = 32'h0000_00F0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wide,
    input  logic [IDX_W-1:0]         idx,
    input  logic [63:0]              wdata,
    output logic [NUM_REGS*32-1:0]   regs_flat
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam wr_rule_e    RULE = rule_of(g, ID_IDX, STRAP_IDX, IRQ_IDX, RST_IDX,
                                               BOOT_IDX, LOCK_IDX, MDIS_IDX);
        localparam logic [31:0] RV   = reset_of(g, ID_IDX, ID_VAL, STRAP_IDX, STRAP_VAL,
                                                RST_IDX, RST_VAL, BOOT_IDX, BOOT_VAL);
        logic [31:0] q, d;

        // Select raw low word, raw high word, or ruled 4-byte update.
        always_comb begin
            d = q;
            if (wr_en && wide && int'(idx) == g)
                d = wdata[31:0];
            else if (wr_en && wide && int'(idx) + 1 == g)
                d = wdata[63:32];
            else if (wr_en && !wide && int'(idx) == g)
                d = apply_rule(RULE, q, wdata[31:0]);
        end

        // Hold the register, loading its reset value on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= RV;
            else        q <= d;
        end

        assign regs_flat[g*32 +: 32] = q;
    end

endmodule

// File: rtl/cr_rdmux.sv
// Module: read data selection for 4-byte and 8-byte reads.
// Assumes the caller masks the result for illegal accesses.
module cr_rdmux #(
    parameter int NUM_REGS = 64,
    parameter int IDX_W    = 10
) (
    input  logic [NUM_REGS*32-1:0] regs_flat,
    input  logic [IDX_W-1:0]       idx,
    input  logic                   wide,
    output logic [63:0]            rdata
);

    logic [31:0] lo, hi;

    // Pick register N and, for wide reads, register N+1.
    always_comb begin
        lo = 32'h0;
        hi = 32'h0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (int'(idx) == i)     lo = regs_flat[i*32 +: 32];
            if (int'(idx) + 1 == i) hi = regs_flat[i*32 +: 32];
        end
        rdata = wide ? {hi, lo} : {32'h0, lo};
    end

endmodule

// File: rtl/ctl_reg_bank.sv
// Module: top of the mixed-access control register bank.
// Takes one request per two cycles; answers with a one-cycle ready pulse
// carrying read data and an error flag. Requests must hold until ready.
module ctl_reg_bank #(
    parameter int          NUM_REGS     = 64,
    parameter int          ADDR_W       = 12,
    parameter int          SCRATCH_BASE = 56,
    parameter int          ID_IDX       = 0,
    parameter int          STRAP_IDX    = 1,
    parameter int          IRQ_IDX      = 2,
    parameter int          RST_IDX      = 3,
    parameter int          BOOT_IDX     = 4,
    parameter int          LOCK_IDX     = 5,
    parameter int          MDIS_IDX     = 6,
    parameter logic [31:0] ID_VAL       = 32'h0A92_1B47,
    parameter logic [31:0] STRAP_VAL    = 32'h0000_3C5F,
    parameter logic [31:0] RST_VAL      = 32'h0000_0001,
    parameter logic [31:0] BOOT_VAL     = 32'h0000_00F0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_size,
    input  logic [63:0]       req_wdata,
    output logic              req_ready,
    output logic [63:0]       rsp_rdata,
    output logic              rsp_err
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]       idx;
    logic                   wide, legal, accept, wr_en;
    logic [63:0]            rd_sel;
    logic [NUM_REGS*32-1:0] regs_flat;
    logic                   ack_q, err_q;
    logic [63:0]            rdata_q;

    cr_decode #(
        .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .SCRATCH_BASE(SCRATCH_BASE),
        .ID_IDX(ID_IDX), .STRAP_IDX(STRAP_IDX), .IRQ_IDX(IRQ_IDX),
        .RST_IDX(RST_IDX), .BOOT_IDX(BOOT_IDX), .LOCK_IDX(LOCK_IDX),
        .MDIS_IDX(MDIS_IDX)
    ) u_decode (
        .addr(req_addr), .size(req_size), .write(req_write),
        .idx(idx), .wide(wide), .legal(legal)
    );

    cr_store #(
        .NUM_REGS(NUM_REGS), .IDX_W(IDX_W),
        .ID_IDX(ID_IDX), .STRAP_IDX(STRAP_IDX), .IRQ_IDX(IRQ_IDX),
        .RST_IDX(RST_IDX), .BOOT_IDX(BOOT_IDX), .LOCK_IDX(LOCK_IDX),
        .MDIS_IDX(MDIS_IDX),
        .ID_VAL(ID_VAL), .STRAP_VAL(STRAP_VAL), .RST_VAL(RST_VAL),
        .BOOT_VAL(BOOT_VAL)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wide(wide),
        .idx(idx), .wdata(req_wdata), .regs_flat(regs_flat)
    );

    cr_rdmux #(
        .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
    ) u_rdmux (
        .regs_flat(regs_flat), .idx(idx), .wide(wide), .rdata(rd_sel)
    );

    // Take a request only while no acknowledge is pending.
    assign accept = req_valid && !ack_q;
    assign wr_en  = accept && req_write && legal;

    // Register the acknowledge, error flag and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= 64'h0;
        end else begin
            ack_q   <= accept;
            err_q   <= accept && !legal;
            rdata_q <= (accept && legal && !req_write) ? rd_sel : 64'h0;
        end
    end

    assign req_ready = ack_q;
    assign rsp_err   = err_q;
    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/cr_bank_checker.sv
// Module: assertion checker bound to ctl_reg_bank.
// Assumes requests hold until acknowledged.
module cr_bank_checker #(
    parameter int NUM_REGS  = 64,
    parameter int ADDR_W    = 12,
    parameter int ID_IDX    = 0,
    parameter int STRAP_IDX = 1,
    parameter int RST_IDX   = 3,
    parameter int LOCK_IDX  = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic [ADDR_W-1:0]      req_addr,
    input logic [3:0]             req_size,
    input logic                   rsp_err,
    input logic [63:0]            rsp_rdata,
    input logic [NUM_REGS*32-1:0] regs_flat
);

    logic [31:0] id_r, strap_r, rst_r, lock_r;
    assign id_r    = regs_flat[ID_IDX*32 +: 32];
    assign strap_r = regs_flat[STRAP_IDX*32 +: 32];
    assign rst_r   = regs_flat[RST_IDX*32 +: 32];
    assign lock_r  = regs_flat[LOCK_IDX*32 +: 32];

    assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    assert_ready_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> req_ready);

    assert_err_with_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> req_ready);

    assert_err_zero_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 64'h0));

    assert_range_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && int'(req_addr[ADDR_W-1:2]) >= NUM_REGS) |=> rsp_err);

    assert_size_err_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && req_size != 4'd4 && req_size != 4'd8) |=> rsp_err);

    assert_ro_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(id_r) && $stable(strap_r));

    assert_w1c_no_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_r & ~$past(rst_r)) == 32'h0);

    assert_w1s_no_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lock_r) & ~lock_r) == 32'h0);

endmodule

bind ctl_reg_bank cr_bank_checker #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .ID_IDX(ID_IDX),
    .STRAP_IDX(STRAP_IDX), .RST_IDX(RST_IDX), .LOCK_IDX(LOCK_IDX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .regs_flat(regs_flat)
);

// File: tb/test_ctl_reg_bank.sv
`timescale 1ns/1ps
module test_ctl_reg_bank;

    localparam int          NR    = 64;
    localparam int          SB    = 56;
    localparam logic [31:0] IDV   = 32'h0A92_1B47;
    localparam logic [31:0] STV   = 32'h0000_3C5F;
    localparam logic [31:0] RSV   = 32'h0000_0001;
    localparam logic [31:0] BTV   = 32'h0000_00F0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [3:0]  req_size = 4'd4;
    logic [63:0] req_wdata = '0;
    logic        req_ready, rsp_err;
    logic [63:0] rsp_rdata;

    int          ncomp = 0, nfail = 0;
    logic [31:0] m [NR];
    bit          exp_r = 1'b0;
    bit          exp_err = 1'b0;
    logic [63:0] exp_rd = '0;
    string       cur_req = "R1";
    bit          done = 1'b0;

    always #4 clk = ~clk;

    ctl_reg_bank i_ctl_reg_bank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        ncomp++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock reference of the handshake and response outputs.
    always @(posedge clk) begin
        exp_r = rst_n ? (req_valid && !exp_r) : 1'b0;
        #2;
        chk(req_ready === exp_r, "R2 ready", {63'h0, req_ready}, {63'h0, exp_r});
        if (exp_r) begin
            chk(rsp_err === exp_err, {cur_req, " err"}, {63'h0, rsp_err}, {63'h0, exp_err});
            chk(rsp_rdata === exp_rd, {cur_req, " rdata"}, rsp_rdata, exp_rd);
        end else begin
            chk(rsp_err === 1'b0, "R2 idle err", {63'h0, rsp_err}, 64'h0);
            chk(rsp_rdata === 64'h0, "R2 idle rdata", rsp_rdata, 64'h0);
        end
    end

    task automatic model_reset();
        for (int i = 0; i < NR; i++) m[i] = 32'h0;
        m[0] = IDV; m[1] = STV; m[3] = RSV; m[4] = BTV;
    endtask

    // One access: compute expected response, drive, then update the model.
    task automatic acc(input string req, input bit wr, input int addr, input int size,
                       input logic [63:0] wd);
        int          idx;
        bit          err;
        logic [63:0] rd;
        idx = addr / 4;
        err = 1'b0;
        if (size != 4 && size != 8)                     err = 1'b1;
        else if (addr % size != 0)                      err = 1'b1;
        else if (idx >= NR)                             err = 1'b1;
        else if (size == 8 && !(idx >= SB && idx < NR - 1)) err = 1'b1;
        else if (wr && size == 4 && idx <= 2)           err = 1'b1;
        rd = 64'h0;
        if (!err && !wr)
            rd = (size == 4) ? {32'h0, m[idx]} : {m[idx+1], m[idx]};
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = 12'(addr);
        req_size = 4'(size); req_wdata = wd;
        exp_err = err; exp_rd = rd; cur_req = req;
        @(negedge clk);
        req_valid = 1'b0;
        if (!err && wr) begin
            if (size == 8) begin
                m[idx] = wd[31:0]; m[idx+1] = wd[63:32];
            end else if (idx == 3 || idx == 4) m[idx] = m[idx] & ~wd[31:0];
            else if (idx == 5 || idx == 6)     m[idx] = m[idx] | wd[31:0];
            else                               m[idx] = wd[31:0];
        end
    endtask

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset contents
        acc("R1", 0, 12'h000, 4, 0);
        acc("R1", 0, 12'h004, 4, 0);
        acc("R1", 0, 12'h00C, 4, 0);
        acc("R1", 0, 12'h010, 4, 0);
        acc("R1", 0, 12'h028, 4, 0);
        // R3 R4: plain registers
        acc("R4", 1, 12'h028, 4, 64'hFFFF_FFFF_A5A5_5A5A);
        acc("R3", 0, 12'h028, 4, 0);
        acc("R4", 1, 12'h050, 4, 64'h1234_5678);
        acc("R3", 0, 12'h050, 4, 0);
        // R5: read-only
        acc("R5", 1, 12'h000, 4, 64'hFFFF_FFFF);
        acc("R5", 1, 12'h004, 4, 64'h0);
        acc("R5", 1, 12'h008, 4, 64'h55);
        acc("R5", 0, 12'h000, 4, 0);
        acc("R5", 0, 12'h004, 4, 0);
        acc("R5", 0, 12'h008, 4, 0);
        // R6: write-one-to-clear
        acc("R6", 1, 12'h00C, 4, 64'h1);
        acc("R6", 0, 12'h00C, 4, 0);
        acc("R6", 1, 12'h010, 4, 64'h0000_0130);
        acc("R6", 0, 12'h010, 4, 0);
        // R7: write-one-to-set
        acc("R7", 1, 12'h014, 4, 64'h3);
        acc("R7", 1, 12'h014, 4, 64'h10);
        acc("R7", 1, 12'h014, 4, 64'h0);
        acc("R7", 0, 12'h014, 4, 0);
        acc("R7", 1, 12'h018, 4, 64'h8000_0000);
        acc("R7", 0, 12'h018, 4, 0);
        // R9 R8: wide accesses in the window
        acc("R9", 1, 12'h0E0, 8, 64'hDEAD_BEEF_CAFE_F00D);
        acc("R8", 0, 12'h0E0, 8, 0);
        acc("R9", 0, 12'h0E4, 4, 0);
        acc("R9", 1, 12'h0F8, 8, 64'h0102_0304_0506_0708);
        acc("R8", 0, 12'h0F8, 8, 0);
        acc("R8", 0, 12'h0FC, 4, 0);
        acc("R4", 1, 12'h0F0, 4, 64'h7777_7777);
        acc("R8", 0, 12'h0F0, 8, 0);
        // R10: wide accesses outside the window
        acc("R10", 1, 12'h0D8, 8, 64'h1111_2222_3333_4444);
        acc("R10", 0, 12'h0D8, 8, 0);
        acc("R10", 1, 12'h028, 8, 64'h9999_8888_7777_6666);
        acc("R10", 0, 12'h028, 4, 0);
        acc("R10", 0, 12'h02C, 4, 0);
        acc("R10", 1, 12'h008, 8, 64'h0);
        // R11: out of range
        acc("R11", 0, 12'h100, 4, 0);
        acc("R11", 0, 12'hFFC, 4, 0);
        acc("R11", 1, 12'h200, 4, 64'hABCD);
        acc("R11", 0, 12'h100, 8, 0);
        // R12: bad sizes and misalignment
        acc("R12", 1, 12'h028, 2, 64'h0);
        acc("R12", 1, 12'h028, 1, 64'h0);
        acc("R12", 0, 12'h028, 12, 0);
        acc("R12", 0, 12'h028, 0, 0);
        acc("R12", 1, 12'h02A, 4, 64'h0);
        acc("R12", 1, 12'h0E4, 8, 64'hFFFF_FFFF_FFFF_FFFF);
        acc("R12", 0, 12'h028, 4, 0);
        acc("R12", 0, 12'h0E0, 8, 0);
        acc("R12", 0, 12'h0E8, 8, 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncomp, nfail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 100000);
        if (!done) begin
            ncomp++;
            nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncomp, nfail);
            $finish;
        end
    end

endmodule